// File: doc/BRIEF.md
# USB Endpoint DMA Buffer Controller

This block holds the control and status logic for a single DMA channel that moves packet data between a USB device endpoint and system memory. Software writes one 32-bit control word. The word carries a two-bit channel command, six enable bits and a 16-bit buffer byte length. Each write that issues a command other than stop-now also loads a remaining-byte counter. The data path reports each accepted beat together with its byte count, and the counter falls by that amount.

The current buffer closes in one of two ways. The first is the counter reaching zero. The second is an endpoint end event (a short packet, or the last packet of an isochronous frame) on an OUT channel that has early termination enabled. Each close sets a sticky status flag. A descriptor-loaded event sets a third sticky flag. A single interrupt line reports any flag whose own enable is set. A status read clears the flags.

The burst-lock enable holds a bus-lock output across each packet's data burst.

Top module: `usb_dma_buf_ctrl`

## Requirements
- R1: After reset, remain_o is 65536. chan_act_o, beat_ready_o, all three status flags, pkt_valid_o, bus_lock_o and irq_o are 0.
- R2: A write whose bits [1:0] are not 00 stores the whole word. The same write loads remain_o with bits [31:16], where 0 means 65536, visible on the next cycle.
- R3: A write with bits [1:0] = 00 (stop now) changes only the command bits. It leaves the enables and remain_o unchanged and clears chan_act_o on the next cycle.
- R4: Each accepted beat (beat_valid_i while beat_ready_o) lowers remain_o by beat_bytes_i on the next cycle. A byte count larger than the remainder is clipped, so remain_o stops at 0.
- R5: A beat that brings a non-zero remainder to zero sets eob_st_o on the next cycle and closes the buffer.
- R6: ep_end_i while the channel is active, dir_out_i = 1 and bit 2 is set sets eot_st_o and closes the buffer on the next cycle. Otherwise ep_end_i is ignored.
- R7: When bit 3 is set, the beat that reaches zero causes a one-cycle pkt_valid_o pulse on the next cycle.
- R8: irq_o is high exactly while (eot_st_o and bit 4), (eob_st_o and bit 5) or (desc_st_o and bit 6) holds.
- R9: desc_loaded_i sets desc_st_o on the next cycle.
- R10: A stat_rd_i pulse clears all three flags on the next cycle. An event in the same cycle wins, and its flag stays set.
- R11: Command 01 (run) raises chan_act_o on the next cycle. A close or stop-now lowers it. beat_ready_o equals chan_act_o, and beats are not accepted while it is low.
- R12: With bit 7 set, bus_lock_o rises the cycle after burst_start_i and falls the cycle after burst_end_i. With bit 7 clear it stays 0.
- R13: A zero-reaching beat and a qualifying endpoint end event in the same cycle set both eob_st_o and eot_st_o. The buffer closes once and pkt_valid_o pulses once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 32 | Control word write data |
| dir_out_i | input | 1 | 1 = OUT channel (host to device) |
| beat_valid_i | input | 1 | Data path offers a beat |
| beat_bytes_i | input | 3 | Byte count of the offered beat, 1 to 4 |
| beat_ready_o | output | 1 | Channel accepts beats |
| ep_end_i | input | 1 | Endpoint short or last-packet event |
| desc_loaded_i | input | 1 | Descriptor-loaded event |
| burst_start_i | input | 1 | Packet data burst begins |
| burst_end_i | input | 1 | Packet data burst ends |
| stat_rd_i | input | 1 | Status read, clears the sticky flags |
| remain_o | output | 17 | Remaining byte count |
| chan_act_o | output | 1 | Channel active |
| eob_st_o | output | 1 | Sticky end-of-buffer flag |
| eot_st_o | output | 1 | Sticky end-of-transfer flag |
| desc_st_o | output | 1 | Sticky descriptor-loaded flag |
| pkt_valid_o | output | 1 | Packet validate pulse to the endpoint |
| bus_lock_o | output | 1 | Bus lock request |
| irq_o | output | 1 | Interrupt |

## Verification
Every result is a register, so each one is due one clock after the edge that samples its stimulus. This holds for the counter, chan_act_o, the flags, pkt_valid_o and the lock. irq_o and beat_ready_o are derived from those registers without any path from an input, so they move in the same cycle as the registers. The bench applies inputs at the falling edge and advances its reference model on the rising edge. It compares every output at the next falling edge, half a period after the registers update. The same-cycle cases, read-clear against a new event and a zero count against an endpoint end, are driven in a single cycle and checked one edge later.

// File: rtl/usb_dma_pkg.sv
package usb_dma_pkg;
  localparam int CMD_W   = 2;
  localparam int LEN_LSB = 16;

  typedef enum logic [CMD_W-1:0] {
    CMD_STOP = 2'b00,
    CMD_RUN  = 2'b01,
    CMD_LOAD = 2'b10,
    CMD_CFG  = 2'b11
  } cmd_e;

  localparam int B_EOT_EN   = 2;
  localparam int B_EOB_VAL  = 3;
  localparam int B_EOT_IRQ  = 4;
  localparam int B_EOB_IRQ  = 5;
  localparam int B_DESC_IRQ = 6;
  localparam int B_LOCK_EN  = 7;

  typedef struct packed {
    logic lock_en;
    logic desc_irq_en;
    logic eob_irq_en;
    logic eot_irq_en;
    logic eob_val_en;
    logic eot_en;
  } ctl_t;
endpackage

// File: rtl/udma_ctl_reg.sv
module udma_ctl_reg
  import usb_dma_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [LEN_LSB+LEN_W-1:0]   wdata_i,
  output ctl_t                       ctl_o,
  output logic                       load_o,
  output logic [LEN_W-1:0]           load_len_o,
  output logic                       run_o,
  output logic                       stop_o
);
  localparam int DATA_W = LEN_LSB + LEN_W;

  logic [DATA_W-1:0] ctl_q;
  cmd_e              wcmd;

  assign wcmd       = cmd_e'(wdata_i[CMD_W-1:0]);
  assign load_o     = we_i && (wcmd != CMD_STOP);
  assign run_o      = we_i && (wcmd == CMD_RUN);
  assign stop_o     = we_i && (wcmd == CMD_STOP);
  assign load_len_o = wdata_i[DATA_W-1:LEN_LSB];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else if (we_i) begin
      if (wcmd != CMD_STOP) ctl_q <= wdata_i;
      else                  ctl_q[CMD_W-1:0] <= wdata_i[CMD_W-1:0];
    end
  end

  assign ctl_o = '{lock_en:     ctl_q[B_LOCK_EN],
                   desc_irq_en: ctl_q[B_DESC_IRQ],
                   eob_irq_en:  ctl_q[B_EOB_IRQ],
                   eot_irq_en:  ctl_q[B_EOT_IRQ],
                   eob_val_en:  ctl_q[B_EOB_VAL],
                   eot_en:      ctl_q[B_EOT_EN]};

  p_stop_keeps_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> ctl_q[DATA_W-1:CMD_W] == $past(ctl_q[DATA_W-1:CMD_W]));
  p_write_stores_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> ctl_q == $past(wdata_i));
endmodule

// File: rtl/udma_byte_cnt.sv
module udma_byte_cnt #(
  parameter int LEN_W  = 16,
  parameter int BEAT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] load_len_i,
  input  logic             act_i,
  input  logic             beat_valid_i,
  input  logic [BEAT_W-1:0] beat_bytes_i,
  output logic [LEN_W:0]   remain_o,
  output logic             eob_evt_o
);
  localparam int CNT_W = LEN_W + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(1) << LEN_W;

  logic [CNT_W-1:0] rem_q, beat_ext;
  logic             accept;

  assign beat_ext  = CNT_W'(beat_bytes_i);
  assign accept    = act_i && beat_valid_i;
  assign eob_evt_o = accept && (rem_q != '0) && (beat_ext != '0) && (beat_ext >= rem_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= FULL;
    end else if (load_i) begin
      rem_q <= (load_len_i == '0) ? FULL : {1'b0, load_len_i};
    end else if (accept) begin
      if (beat_ext >= rem_q) rem_q <= '0;
      else                   rem_q <= rem_q - beat_ext;
    end
  end

  assign remain_o = rem_q;

  p_no_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !load_i) |=> rem_q <= $past(rem_q));
  p_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_q <= FULL);
  p_load_nonzero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> rem_q != '0);
  p_zero_after_eob_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eob_evt_o && !load_i) |=> rem_q == '0);
endmodule

// File: rtl/udma_stat_irq.sv
module udma_stat_irq
  import usb_dma_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  ctl_t ctl_i,
  input  logic run_i,
  input  logic stop_i,
  input  logic eob_evt_i,
  input  logic ep_end_i,
  input  logic dir_out_i,
  input  logic desc_ld_i,
  input  logic rd_i,
  input  logic burst_start_i,
  input  logic burst_end_i,
  output logic act_o,
  output logic eob_st_o,
  output logic eot_st_o,
  output logic desc_st_o,
  output logic pkt_valid_o,
  output logic lock_o,
  output logic irq_o
);
  logic act_q, eob_q, eot_q, desc_q, pv_q, lock_q;
  logic eot_evt;

  // endpoint termination only on an active OUT channel with early end enabled
  assign eot_evt = act_q && ep_end_i && dir_out_i && ctl_i.eot_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      eob_q  <= 1'b0;
      eot_q  <= 1'b0;
      desc_q <= 1'b0;
      pv_q   <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      if (run_i)                                act_q <= 1'b1;
      else if (stop_i || eob_evt_i || eot_evt) act_q <= 1'b0;

      if (eob_evt_i) eob_q  <= 1'b1; else if (rd_i) eob_q  <= 1'b0;
      if (eot_evt)   eot_q  <= 1'b1; else if (rd_i) eot_q  <= 1'b0;
      if (desc_ld_i) desc_q <= 1'b1; else if (rd_i) desc_q <= 1'b0;

      pv_q <= eob_evt_i && ctl_i.eob_val_en;

      if (burst_start_i)    lock_q <= 1'b1;
      else if (burst_end_i) lock_q <= 1'b0;
    end
  end

  assign act_o       = act_q;
  assign eob_st_o    = eob_q;
  assign eot_st_o    = eot_q;
  assign desc_st_o   = desc_q;
  assign pkt_valid_o = pv_q;
  assign lock_o      = lock_q && ctl_i.lock_en;
  assign irq_o       = (eot_q && ctl_i.eot_irq_en) || (eob_q && ctl_i.eob_irq_en)
                    || (desc_q && ctl_i.desc_irq_en);

  p_eob_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eob_q && !rd_i) |=> eob_q);
  p_eob_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eob_evt_i |=> (eob_q && (!act_q || $past(run_i))));
  p_eot_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && !ctl_i.eot_en && !eob_evt_i && !stop_i) |=> act_q);
  p_rd_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !eob_evt_i) |=> !eob_q);
  p_desc_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_ld_i |=> desc_q);
  p_pv_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pv_q |=> !pv_q);
  p_lock_rise_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> $past(burst_start_i));
  p_close_once_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eob_evt_i && eot_evt && !run_i) |=> (!act_q && eob_q && eot_q));
endmodule

// File: rtl/usb_dma_buf_ctrl.sv
module usb_dma_buf_ctrl
  import usb_dma_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int BEAT_W = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ctl_we_i,
  input  logic [LEN_LSB+LEN_W-1:0] ctl_wdata_i,
  input  logic                     dir_out_i,
  input  logic                     beat_valid_i,
  input  logic [BEAT_W-1:0]        beat_bytes_i,
  output logic                     beat_ready_o,
  input  logic                     ep_end_i,
  input  logic                     desc_loaded_i,
  input  logic                     burst_start_i,
  input  logic                     burst_end_i,
  input  logic                     stat_rd_i,
  output logic [LEN_W:0]           remain_o,
  output logic                     chan_act_o,
  output logic                     eob_st_o,
  output logic                     eot_st_o,
  output logic                     desc_st_o,
  output logic                     pkt_valid_o,
  output logic                     bus_lock_o,
  output logic                     irq_o
);
  ctl_t             ctl;
  logic             load, run, stop, eob_evt;
  logic [LEN_W-1:0] load_len;

  udma_ctl_reg #(.LEN_W(LEN_W)) u_ctl (
    .clk_i, .rst_ni,
    .we_i       (ctl_we_i),
    .wdata_i    (ctl_wdata_i),
    .ctl_o      (ctl),
    .load_o     (load),
    .load_len_o (load_len),
    .run_o      (run),
    .stop_o     (stop)
  );

  udma_byte_cnt #(.LEN_W(LEN_W), .BEAT_W(BEAT_W)) u_cnt (
    .clk_i, .rst_ni,
    .load_i       (load),
    .load_len_i   (load_len),
    .act_i        (chan_act_o),
    .beat_valid_i (beat_valid_i),
    .beat_bytes_i (beat_bytes_i),
    .remain_o     (remain_o),
    .eob_evt_o    (eob_evt)
  );

  udma_stat_irq u_stat (
    .clk_i, .rst_ni,
    .ctl_i         (ctl),
    .run_i         (run),
    .stop_i        (stop),
    .eob_evt_i     (eob_evt),
    .ep_end_i      (ep_end_i),
    .dir_out_i     (dir_out_i),
    .desc_ld_i     (desc_loaded_i),
    .rd_i          (stat_rd_i),
    .burst_start_i (burst_start_i),
    .burst_end_i   (burst_end_i),
    .act_o         (chan_act_o),
    .eob_st_o      (eob_st_o),
    .eot_st_o      (eot_st_o),
    .desc_st_o     (desc_st_o),
    .pkt_valid_o   (pkt_valid_o),
    .lock_o        (bus_lock_o),
    .irq_o         (irq_o)
  );

  assign beat_ready_o = chan_act_o;

  p_stop_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && ctl_wdata_i[CMD_W-1:0] == CMD_STOP) |=> !chan_act_o);
  p_no_accept_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!beat_ready_o && !ctl_we_i) |=> $stable(remain_o));
endmodule

// File: tb/usb_dma_buf_ctrl_bench.sv
`timescale 1ns/1ps
module usb_dma_buf_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 0, dir_out = 0, beat_valid = 0, ep_end = 0;
  logic        desc_ld = 0, bstart = 0, bend = 0, stat_rd = 0;
  logic [31:0] ctl_wdata = '0;
  logic [2:0]  beat_bytes = '0;
  logic        beat_ready, chan_act, eob_st, eot_st, desc_st, pkt_valid, bus_lock, irq;
  logic [16:0] remain;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  // reference model state
  int   m_rem = 65536;
  bit   m_act = 0, m_eob = 0, m_eot = 0, m_desc = 0, m_pv = 0, m_lock = 0;
  logic [31:0] m_ctl = '0;

  always #2.5 clk = ~clk;

  usb_dma_buf_ctrl u_usb_dma_buf_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata),
    .dir_out_i(dir_out), .beat_valid_i(beat_valid), .beat_bytes_i(beat_bytes),
    .beat_ready_o(beat_ready), .ep_end_i(ep_end), .desc_loaded_i(desc_ld),
    .burst_start_i(bstart), .burst_end_i(bend), .stat_rd_i(stat_rd),
    .remain_o(remain), .chan_act_o(chan_act), .eob_st_o(eob_st), .eot_st_o(eot_st),
    .desc_st_o(desc_st), .pkt_valid_o(pkt_valid), .bus_lock_o(bus_lock), .irq_o(irq));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rem = 65536; m_act = 0; m_eob = 0; m_eot = 0; m_desc = 0;
      m_pv = 0; m_lock = 0; m_ctl = '0;
    end else begin
      automatic bit eob_e = 0;
      automatic bit eot_e = m_act && ep_end && dir_out && m_ctl[2];
      automatic int nrem = m_rem;
      if (m_act && beat_valid && beat_bytes != 0) begin
        if (beat_bytes >= m_rem) begin
          if (m_rem > 0) eob_e = 1;
          nrem = 0;
        end else nrem = m_rem - beat_bytes;
      end
      m_pv = eob_e && m_ctl[3];
      if (ctl_we && ctl_wdata[1:0] == 2'b01) m_act = 1;
      else if ((ctl_we && ctl_wdata[1:0] == 2'b00) || eob_e || eot_e) m_act = 0;
      if (eob_e) m_eob = 1; else if (stat_rd) m_eob = 0;
      if (eot_e) m_eot = 1; else if (stat_rd) m_eot = 0;
      if (desc_ld) m_desc = 1; else if (stat_rd) m_desc = 0;
      if (bstart) m_lock = 1; else if (bend) m_lock = 0;
      if (ctl_we && ctl_wdata[1:0] != 2'b00) begin
        m_ctl = ctl_wdata;
        nrem = (ctl_wdata[31:16] == 0) ? 65536 : int'(ctl_wdata[31:16]);
      end else if (ctl_we) m_ctl[1:0] = ctl_wdata[1:0];
      m_rem = nrem;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      cyc++;
      chk("R4 remain_o", remain, m_rem);
      chk("R11 chan_act_o", chan_act, m_act);
      chk("R11 beat_ready_o", beat_ready, m_act);
      chk("R5 eob_st_o", eob_st, m_eob);
      chk("R6 eot_st_o", eot_st, m_eot);
      chk("R9 desc_st_o", desc_st, m_desc);
      chk("R7 pkt_valid_o", pkt_valid, m_pv);
      chk("R12 bus_lock_o", bus_lock, m_lock && m_ctl[7]);
      chk("R8 irq_o", irq, (m_eot && m_ctl[4]) || (m_eob && m_ctl[5]) || (m_desc && m_ctl[6]));
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    ctl_we = 0; beat_valid = 0; ep_end = 0; desc_ld = 0;
    bstart = 0; bend = 0; stat_rd = 0;
  endtask

  // flags: {lock, desc_irq, eob_irq, eot_irq, eob_val, eot_en}
  task automatic wr(logic [1:0] cmd, logic [5:0] flags, logic [15:0] len);
    ctl_we = 1; ctl_wdata = {len, 8'h00, flags, cmd};
    step();
  endtask

  task automatic beat(int n);
    beat_valid = 1; beat_bytes = 3'(n);
    step();
  endtask

  task automatic summary();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset remain", remain, 65536);
    chk("R1 reset act", chan_act, 0);
    chk("R1 reset irq", irq, 0);
    chk("R1 reset flags", {eob_st, eot_st, desc_st, pkt_valid, bus_lock}, 0);
    step(); step();

    wr(2'b10, 6'b000000, 16'd0);
    chk("R2 zero length", remain, 65536);
    wr(2'b01, 6'b001010, 16'd10);
    chk("R2 load length", remain, 10);
    beat(4); beat(4); beat(4);
    chk("R5 eob flag", eob_st, 1);
    chk("R7 validate pulse", pkt_valid, 1);
    chk("R4 clip to zero", remain, 0);
    beat(4);
    chk("R11 idle ignores beat", remain, 0);

    stat_rd = 1; desc_ld = 1; step();
    chk("R10 read clears eob", eob_st, 0);
    chk("R10 event beats read", desc_st, 1);

    wr(2'b01, 6'b010001, 16'd100);
    beat(3);
    dir_out = 0; ep_end = 1; step();
    chk("R6 IN ignores end", chan_act, 1);
    dir_out = 1; ep_end = 1; step();
    chk("R6 eot flag", eot_st, 1);
    chk("R6 eot closes", chan_act, 0);

    wr(2'b01, 6'b000000, 16'd50);
    ep_end = 1; step();
    chk("R6 disabled end ignored", chan_act, 1);
    beat(2); beat(2);
    wr(2'b00, 6'b111111, 16'd7);
    chk("R3 stop keeps count", remain, 46);
    chk("R3 stop deactivates", chan_act, 0);
    chk("R3 stop keeps enables", irq, 0);
    beat(1);

    wr(2'b01, 6'b000011, 16'd4);
    beat_valid = 1; beat_bytes = 3'd4; ep_end = 1; step();
    chk("R13 both flags", {eob_st, eot_st}, 2'b11);
    chk("R13 single close", chan_act, 0);
    chk("R13 validate", pkt_valid, 1);
    step();
    chk("R13 one pulse", pkt_valid, 0);

    wr(2'b10, 6'b100000, 16'd20);
    bstart = 1; step();
    chk("R12 lock on", bus_lock, 1);
    step();
    bend = 1; step();
    chk("R12 lock off", bus_lock, 0);
    wr(2'b10, 6'b000000, 16'd20);
    bstart = 1; step();
    chk("R12 lock disabled", bus_lock, 0);
    bend = 1; step();

    stat_rd = 1; step();
    wr(2'b01, 6'b001000, 16'd300);
    for (int i = 0; i < 120; i++) begin
      beat_valid = (i % 3) != 0;
      beat_bytes = 3'(i % 5);
      stat_rd = (i % 17) == 0;
      desc_ld = (i % 23) == 5;
      step();
    end
    wr(2'b01, 6'b011100, 16'd0);
    for (int i = 0; i < 40; i++) begin
      beat_valid = 1; beat_bytes = 3'(1 + i % 4);
      bstart = (i % 10) == 0; bend = (i % 10) == 6;
      step();
    end
    step();
    summary();
  end
endmodule